// File: doc/BRIEF.md
# Four-Channel Trim and Master Attenuation Combiner

This block turns two volume codes per channel into one attenuation figure for an analog gain stage. Each of the four channels takes a 4-bit fine trim code and a 5-bit master code. The block adds the decibel values of the two codes and returns the total as an unsigned magnitude in whole decibels.

The master code follows a piecewise law. Low codes step in 2 dB increments. Higher codes step in 4 dB increments. The all-ones code means full mute. The total never goes beyond 87 dB: a deeper sum, or a mute, returns exactly 87.

The four channels share identical logic and are evaluated in parallel. In the default registered build, a new set of codes is taken when the input strobe is high. The results and a matching output strobe appear one clock later, and the outputs hold their values while the strobe is low. A parameter selects a purely combinational build instead.

Top module: `vol_combiner`

## Requirements
- R1: A trim code n (0 to 15), paired with master code 0, yields exactly n dB of attenuation with mute low.
- R2: Master codes 0 to 22 contribute 2 dB per code step (code c gives 2c dB, up to 44 dB), which is added to the trim value.
- R3: Master codes 23 to 30 contribute 48 + 4(c-23) dB (48 to 76 dB), which is added to the trim value.
- R4: Master code 31 asserts mute for that channel and forces its attenuation to 87, whatever the trim code.
- R5: When trim plus master is 87 dB or more, and the master code is not 31, the attenuation is exactly 87 and mute stays low.
- R6: Each of the four channels computes its result from its own code pair only. Channel k uses bits [4k+3:4k] of the trim bus and bits [5k+4:5k] of the master bus, and drives bits [7k+6:7k] of the attenuation bus.
- R7: In the registered build, codes sampled at a rising clock edge with valid_i high appear on atten_o and mute_o after that edge. valid_o equals valid_i as it was at the previous edge.
- R8: In the registered build, a clock edge with valid_i low leaves atten_o and mute_o unchanged, whatever codes are present at that edge.
- R9: While rst_ni is low, every channel reads attenuation 87 with mute high, and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: sample the code buses at this edge |
| trim_i | input | 16 | Trim codes, 4 bits per channel, channel 0 in the LSBs |
| master_i | input | 20 | Master codes, 5 bits per channel, channel 0 in the LSBs |
| valid_o | output | 1 | Strobe: outputs carry a freshly sampled result |
| atten_o | output | 28 | Total attenuation in dB (0 to 87), 7 bits per channel |
| mute_o | output | 4 | Per-channel mute flag |

## Verification
In the registered build, every result is due exactly one rising edge after the edge that samples valid_i high. The bench changes codes and the strobe at the falling edge. It waits for the following rising edge and compares at the next falling edge, so each comparison sees only the freshly loaded value.

The hold case is checked the same way. The bench presents new codes with the strobe low, lets one rising edge pass, and then confirms at the falling edge that the previous results are still present and that valid_o is low.

The reset values are read at a falling edge while reset is still asserted.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int unsigned TRIM_W   = 4;
  localparam int unsigned MASTER_W = 5;
  localparam int unsigned ATT_W    = 7;
  localparam int unsigned ATT_MAX  = 87;

  typedef struct packed {
    logic [ATT_W-1:0] att;
    logic             mute;
  } chan_res_t;
endpackage

// File: rtl/vol_master_dec.sv
module vol_master_dec
  import vol_pkg::*;
#(
  parameter int unsigned FINE_LAST   = 22,
  parameter int unsigned FINE_STEP   = 2,
  parameter int unsigned COARSE_STEP = 4
) (
  input  logic [MASTER_W-1:0] code_i,
  output logic [ATT_W-1:0]    base_o,
  output logic                mute_o
);
  localparam int unsigned MUTE_CODE    = (1 << MASTER_W) - 1;
  localparam int unsigned COARSE_START = FINE_LAST * FINE_STEP + COARSE_STEP;
  localparam int unsigned COARSE_FIRST = FINE_LAST + 1;

  logic [ATT_W-1:0] code_w;
  logic [ATT_W-1:0] coarse_idx;

  assign code_w     = ATT_W'(code_i);
  assign coarse_idx = code_w - ATT_W'(COARSE_FIRST);

  always_comb begin
    mute_o = 1'b0;
    base_o = '0;
    if (code_w == ATT_W'(MUTE_CODE)) begin
      mute_o = 1'b1;
    end else if (code_w <= ATT_W'(FINE_LAST)) begin
      base_o = code_w * ATT_W'(FINE_STEP);
    end else begin
      base_o = ATT_W'(COARSE_START) + coarse_idx * ATT_W'(COARSE_STEP);
    end
  end
endmodule

// File: rtl/vol_sum_clamp.sv
module vol_sum_clamp
  import vol_pkg::*;
(
  input  logic [TRIM_W-1:0] trim_i,
  input  logic [ATT_W-1:0]  base_i,
  input  logic              mute_i,
  output chan_res_t         res_o
);
  logic [ATT_W:0] sum;
  logic           sat;

  assign sum = {1'b0, base_i} + (ATT_W+1)'(trim_i);
  assign sat = mute_i || (sum >= (ATT_W+1)'(ATT_MAX));

  always_comb begin
    res_o.mute = mute_i;
    res_o.att  = sat ? ATT_W'(ATT_MAX) : sum[ATT_W-1:0];
  end
endmodule

// File: rtl/vol_chan.sv
module vol_chan
  import vol_pkg::*;
(
  input  logic [TRIM_W-1:0]   trim_i,
  input  logic [MASTER_W-1:0] master_i,
  output chan_res_t           res_o
);
  logic [ATT_W-1:0] base;
  logic             mute;

  vol_master_dec #(
    .FINE_LAST  (22),
    .FINE_STEP  (2),
    .COARSE_STEP(4)
  ) u_dec (
    .code_i(master_i),
    .base_o(base),
    .mute_o(mute)
  );

  vol_sum_clamp u_sum (
    .trim_i(trim_i),
    .base_i(base),
    .mute_i(mute),
    .res_o (res_o)
  );
endmodule

// File: rtl/vol_combiner.sv
module vol_combiner
  import vol_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [NCH*TRIM_W-1:0]   trim_i,
  input  logic [NCH*MASTER_W-1:0] master_i,
  output logic                    valid_o,
  output logic [NCH*ATT_W-1:0]    atten_o,
  output logic [NCH-1:0]          mute_o
);
  chan_res_t res_c [NCH];
  chan_res_t res_q [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    vol_chan u_chan (
      .trim_i  (trim_i[k*TRIM_W +: TRIM_W]),
      .master_i(master_i[k*MASTER_W +: MASTER_W]),
      .res_o   (res_c[k])
    );

    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          res_q[k] <= '{att: ATT_W'(ATT_MAX), mute: 1'b1};
        end else if (valid_i) begin
          res_q[k] <= res_c[k];
        end
      end
    end else begin : g_comb
      assign res_q[k] = res_c[k];
    end

    assign atten_o[k*ATT_W +: ATT_W] = res_q[k].att;
    assign mute_o[k]                 = res_q[k].mute;
  end

  if (REGISTERED) begin : g_vld_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_o <= 1'b0;
      else         valid_o <= valid_i;
    end
  end else begin : g_vld_comb
    assign valid_o = valid_i;
  end
endmodule

// File: rtl/vol_combiner_chk.sv
module vol_combiner_chk
  import vol_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter bit          REGISTERED = 1'b1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [NCH*MASTER_W-1:0] master_i,
  input logic                    valid_o,
  input logic [NCH*ATT_W-1:0]    atten_o,
  input logic [NCH-1:0]          mute_o
);
  localparam logic [MASTER_W-1:0] MUTE_CODE = '1;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    AST_ATT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      atten_o[k*ATT_W +: ATT_W] <= ATT_W'(ATT_MAX)); // R5
    AST_MUTE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mute_o[k] |-> atten_o[k*ATT_W +: ATT_W] == ATT_W'(ATT_MAX)); // R4
    if (REGISTERED) begin : g_reg
      AST_MUTE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && master_i[k*MASTER_W +: MASTER_W] == MUTE_CODE) |=> mute_o[k]); // R4
      AST_UNMUTE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && master_i[k*MASTER_W +: MASTER_W] != MUTE_CODE) |=> !mute_o[k]); // R5
      AST_HOLD_ATT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(atten_o[k*ATT_W +: ATT_W]) && $stable(mute_o[k])); // R8
    end
  end

  if (REGISTERED) begin : g_vld
    AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R7
    AST_VALID_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R7
  end
endmodule

bind vol_combiner vol_combiner_chk #(
  .NCH       (NCH),
  .REGISTERED(REGISTERED)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .master_i(master_i),
  .valid_o (valid_o),
  .atten_o (atten_o),
  .mute_o  (mute_o)
);

// File: tb/vol_combiner_bench.sv
module vol_combiner_bench;
  localparam int NCH = 4;
  localparam int TW  = 4;
  localparam int MW  = 5;
  localparam int AW  = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [NCH*TW-1:0] trim_i = '0;
  logic [NCH*MW-1:0] master_i = '0;
  logic              valid_o;
  logic [NCH*AW-1:0] atten_o;
  logic [NCH-1:0]    mute_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  vol_combiner u_vol_combiner (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .trim_i  (trim_i),
    .master_i(master_i),
    .valid_o (valid_o),
    .atten_o (atten_o),
    .mute_o  (mute_o)
  );

  function automatic int exp_att(int t, int m);
    int base;
    if (m == 31) return 87;
    base = (m <= 22) ? 2 * m : 48 + 4 * (m - 23);
    return (t + base >= 87) ? 87 : t + base;
  endfunction

  function automatic string tag_of(int t, int m);
    int base;
    if (m == 31) return "R4";
    base = (m <= 22) ? 2 * m : 48 + 4 * (m - 23);
    if (t + base >= 87) return "R5";
    if (m == 0) return "R1";
    if (m <= 22) return "R2";
    return "R3";
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_chan(string req, int k, int t, int m);
    check_eq(req, $sformatf("ch%0d att t=%0d m=%0d", k, t, m),
             int'(atten_o[k*AW +: AW]), exp_att(t, m));
    check_eq(req, $sformatf("ch%0d mute t=%0d m=%0d", k, t, m),
             int'(mute_o[k]), (m == 31) ? 1 : 0);
  endtask

  int cur_t[NCH];
  int cur_m[NCH];

  task automatic load(bit v);
    for (int k = 0; k < NCH; k++) begin
      trim_i[k*TW +: TW]   = TW'(cur_t[k]);
      master_i[k*MW +: MW] = MW'(cur_m[k]);
    end
    valid_i = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int held_t[NCH];
    int held_m[NCH];
    // R9: reset values
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < NCH; k++) begin
      check_eq("R9", $sformatf("ch%0d reset att", k), int'(atten_o[k*AW +: AW]), 87);
      check_eq("R9", $sformatf("ch%0d reset mute", k), int'(mute_o[k]), 1);
    end
    check_eq("R9", "reset valid_o", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1..R6 exhaustive sweep; every channel sees all pairs via a bijective remap
    for (int t = 0; t < 16; t++) begin
      for (int m = 0; m < 32; m++) begin
        for (int k = 0; k < NCH; k++) begin
          cur_t[k] = (t + k) % 16;
          cur_m[k] = (m + 7 * k) % 32;
        end
        load(1'b1);
        @(negedge clk_i);
        valid_i = 1'b0;
        check_eq("R7", "valid_o after strobe", int'(valid_o), 1);
        for (int k = 0; k < NCH; k++)
          check_chan(tag_of(cur_t[k], cur_m[k]), k, cur_t[k], cur_m[k]);
      end
    end

    // R6: distinct pairs per channel, each channel in a different region
    cur_t[0] = 3;  cur_m[0] = 0;
    cur_t[1] = 7;  cur_m[1] = 10;
    cur_t[2] = 2;  cur_m[2] = 27;
    cur_t[3] = 15; cur_m[3] = 31;
    load(1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 0; k < NCH; k++) check_chan("R6", k, cur_t[k], cur_m[k]);

    // R8: new codes with strobe low must not reach the outputs
    for (int k = 0; k < NCH; k++) begin
      held_t[k] = cur_t[k];
      held_m[k] = cur_m[k];
      cur_t[k]  = 15 - cur_t[k];
      cur_m[k]  = (cur_m[k] + 5) % 32;
    end
    load(1'b0);
    @(negedge clk_i);
    check_eq("R7", "valid_o with strobe low", int'(valid_o), 0);
    for (int k = 0; k < NCH; k++) check_chan("R8", k, held_t[k], held_m[k]);

    // R7: same codes then strobed take effect one edge later
    load(1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    check_eq("R7", "valid_o after restrobe", int'(valid_o), 1);
    for (int k = 0; k < NCH; k++) check_chan("R7", k, cur_t[k], cur_m[k]);

    // R5 boundary: sum of exactly 86 and 87
    for (int k = 0; k < NCH; k++) begin
      cur_t[k] = (k < 2) ? 10 : 11;
      cur_m[k] = 30;
    end
    load(1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 0; k < NCH; k++) check_chan("R5", k, cur_t[k], cur_m[k]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule